// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Gating

This block serialises parallel characters onto a single transmit line. A character is handed over through a ready/valid pair, packed into a frame made of a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. Bit timing comes from a single-cycle enable pulse, `tick16`. In the normal mode the block counts sixteen pulses per bit. In the external-clock mode each pulse is one whole bit.

Flow control is optional. When it is enabled, the block looks at the active-low clear-to-send input whenever it is about to open a new frame. While that input is high, the line stays at mark and the waiting character is held. Once a frame has started, the input no longer matters until that frame is over. The character format (length, parity and stop length) is captured when a character is accepted. Later changes to the format inputs therefore never reshape a character that is already queued or already on the line.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame is a start bit at 0, then the data bits LSB first, then the stop period at 1. The line rests at 1 whenever `busy` is 0. `len_code` 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits.
- R3: With `one_x_mode` at 0, every start, data and parity bit lasts exactly 16 `tick16` pulses. The line changes only on a tick, except when a frame opens from rest.
- R4: With `par_en` at 1, a parity bit follows the last data bit. With `par_odd` at 0 the count of ones over the data and parity bits is even; with `par_odd` at 1 it is odd.
- R5: With `one_x_mode` at 0, the stop period lasts 9, 16, 24 or 32 ticks for `stop_code` 00, 01, 10 and 11.
- R6: With 5 data bits and `stop_code` 00, the stop period is 16 ticks.
- R7: With `one_x_mode` at 1, each bit lasts one tick. The stop period is 1 tick when `stop_code[1]` is 0 and 2 ticks when it is 1, whatever `stop_code[0]` holds.
- R8: With `cts_en` at 1 and `cts_n` at 1, no frame starts: `txd` stays 1 and `busy` stays 0. The queued character starts after `cts_n` goes to 0.
- R9: A change of `cts_n` after a frame has started leaves that frame unchanged.
- R10: With `cts_en` at 0, `cts_n` has no effect on starting a frame.
- R11: `in_ready` is 1 only when no character is queued and the line is at rest or in a stop period. It is 0 throughout start, data and parity bits. A character accepted during a stop period starts on the tick that ends that stop period.
- R12: The format inputs are captured when a character is accepted. Changes made after acceptance do not alter that character's frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Baud enable pulse (sixteenth of a bit, or a whole bit in the external-clock mode) |
| one_x_mode | input | 1 | 1 = each tick is one whole bit |
| len_code | input | 2 | Data length: 00..11 = 5..8 bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_code | input | 2 | Stop length select |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character; bits above the length are unused |
| in_ready | output | 1 | Character accepted when high together with in_valid |
| txd | output | 1 | Serial output, rests at 1 |
| busy | output | 1 | Frame in progress (start bit through stop period) |

## Verification
A wrong bit counter or shift register shows up within one bit period. The bit lengths, counted in ticks, come out wrong, or the line moves between ticks. A wrong stop counter, or a wrong capture of the stop code, changes the run of ones between two back-to-back frames, and that run is measured tick by tick. A gating fault appears as a start bit in the first tick window while clear-to-send is negated. A fault in the queue slot appears as `in_ready` open during a start bit, or as an idle gap before a character that was queued in a stop period.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned MIN_LEN    = 5;
    localparam int unsigned OVS        = 16;
    localparam int unsigned FRAME_W    = DATA_W + 2;
    localparam int unsigned NB_W       = $clog2(FRAME_W + 1);
    localparam int unsigned CNT_W      = $clog2(2 * OVS + 1);
    localparam int unsigned STOP_FRAC  = (OVS * 9) / 16;
    localparam int unsigned STOP_ONE   = OVS;
    localparam int unsigned STOP_1P5   = (OVS * 3) / 2;
    localparam int unsigned STOP_TWO   = 2 * OVS;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BITS = 2'd1,
        S_STOP = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
        logic [CNT_W-1:0]   stop_ticks;
        logic               one_x;
    } tx_frame_t;
endpackage

// File: rtl/utx_frame_pack.sv
module utx_frame_pack
    import utx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_code,
    input  logic              one_x,
    output tx_frame_t         frame
);
    logic [NB_W-1:0] len_w;
    logic            par_bit;

    assign len_w = NB_W'(MIN_LEN) + NB_W'(len_code);

    always_comb begin
        frame         = '0;
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        par_bit       = par_odd;
        for (int i = 0; i < int'(DATA_W); i++) begin
            if (i < int'(len_w)) begin
                frame.bits[i+1] = data[i];
                par_bit         = par_bit ^ data[i];
            end
        end
        for (int i = int'(MIN_LEN); i <= int'(DATA_W); i++) begin
            if (par_en && (i == int'(len_w))) begin
                frame.bits[i+1] = par_bit;
            end
        end
        frame.nbits = len_w + NB_W'(1) + NB_W'(par_en);
        frame.one_x = one_x;
        if (one_x) begin
            frame.stop_ticks = stop_code[1] ? CNT_W'(2) : CNT_W'(1);
        end else begin
            unique case (stop_code)
                2'b00:   frame.stop_ticks = (len_code == 2'b00) ? CNT_W'(STOP_ONE)
                                                                : CNT_W'(STOP_FRAC);
                2'b01:   frame.stop_ticks = CNT_W'(STOP_ONE);
                2'b10:   frame.stop_ticks = CNT_W'(STOP_1P5);
                default: frame.stop_ticks = CNT_W'(STOP_TWO);
            endcase
        end
    end
endmodule

// File: rtl/utx_hold_slot.sv
module utx_hold_slot
    import utx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    output logic      in_ready,
    input  tx_frame_t frame_in,
    input  logic      load_window,
    input  logic      take,
    output logic      pend_valid,
    output tx_frame_t pend_frame
);
    typedef struct packed {
        logic      full;
        tx_frame_t frame;
    } slot_t;

    slot_t slot_d, slot_q;

    assign in_ready   = !slot_q.full && load_window;
    assign pend_valid = slot_q.full;
    assign pend_frame = slot_q.frame;

    always_comb begin
        slot_d = slot_q;
        if (take) begin
            slot_d.full = 1'b0;
        end
        if (in_valid && in_ready) begin
            slot_d.full  = 1'b1;
            slot_d.frame = frame_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      pend_valid,
    input  tx_frame_t pend_frame,
    input  logic      cts_ok,
    output logic      take,
    output logic      load_window,
    output logic      txd,
    output logic      busy
);
    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [NB_W-1:0]    left;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   stop_ticks;
        logic               one_x;
    } shift_t;

    shift_t sft_d, sft_q;

    logic [CNT_W-1:0] bit_last;
    logic             stop_end;
    logic             start_ok;
    logic             load;

    assign bit_last = sft_q.one_x ? '0 : CNT_W'(OVS - 1);
    assign stop_end = (sft_q.cnt == sft_q.stop_ticks - CNT_W'(1));
    assign start_ok = pend_valid && cts_ok;
    assign load     = start_ok && ((sft_q.st == S_IDLE) ||
                                   ((sft_q.st == S_STOP) && tick && stop_end));

    assign take        = load;
    assign load_window = (sft_q.st != S_BITS);
    assign txd         = (sft_q.st == S_BITS) ? sft_q.sh[0] : 1'b1;
    assign busy        = (sft_q.st != S_IDLE);

    always_comb begin
        sft_d = sft_q;
        unique case (sft_q.st)
            S_IDLE: begin
                sft_d.cnt = '0;
            end
            S_BITS: begin
                if (tick) begin
                    if (sft_q.cnt == bit_last) begin
                        sft_d.cnt = '0;
                        sft_d.sh  = {1'b1, sft_q.sh[FRAME_W-1:1]};
                        if (sft_q.left == NB_W'(1)) begin
                            sft_d.st = S_STOP;
                        end else begin
                            sft_d.left = sft_q.left - NB_W'(1);
                        end
                    end else begin
                        sft_d.cnt = sft_q.cnt + CNT_W'(1);
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (stop_end) begin
                        sft_d.cnt = '0;
                        sft_d.st  = S_IDLE;
                    end else begin
                        sft_d.cnt = sft_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                sft_d.st = S_IDLE;
            end
        endcase
        if (load) begin
            sft_d.st         = S_BITS;
            sft_d.sh         = pend_frame.bits;
            sft_d.left       = pend_frame.nbits;
            sft_d.cnt        = '0;
            sft_d.stop_ticks = pend_frame.stop_ticks;
            sft_d.one_x      = pend_frame.one_x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sft_q.st         <= S_IDLE;
            sft_q.sh         <= '1;
            sft_q.left       <= '0;
            sft_q.cnt        <= '0;
            sft_q.stop_ticks <= '0;
            sft_q.one_x      <= 1'b0;
        end else begin
            sft_q <= sft_d;
        end
    end
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              one_x_mode,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_code,
    input  logic              cts_en,
    input  logic              cts_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);
    tx_frame_t packed_frame;
    tx_frame_t pend_frame;
    logic      pend_valid;
    logic      take;
    logic      load_window;
    logic      cts_ok;

    assign cts_ok = !cts_en || !cts_n;

    utx_frame_pack u_pack (
        .data      (in_data),
        .len_code  (len_code),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_code (stop_code),
        .one_x     (one_x_mode),
        .frame     (packed_frame)
    );

    utx_hold_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .frame_in    (packed_frame),
        .load_window (load_window),
        .take        (take),
        .pend_valid  (pend_valid),
        .pend_frame  (pend_frame)
    );

    utx_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .pend_valid  (pend_valid),
        .pend_frame  (pend_frame),
        .cts_ok      (cts_ok),
        .take        (take),
        .load_window (load_window),
        .txd         (txd),
        .busy        (busy)
    );
endmodule

// File: rtl/utx_tx_chk.sv
module utx_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic cts_en,
    input logic cts_n,
    input logic in_ready,
    input logic txd,
    input logic busy
);
    // R2: the line rests at mark outside a frame
    a_r2_rest_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R11: no acceptance while a start bit is on the line
    a_r11_closed_in_start: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> !in_ready);

    // R8: a frame only opens from rest when clear-to-send permits
    a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cts_en || !cts_n));

    // R3: the line moves only on a tick, apart from opening from rest
    a_r3_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && !$rose(busy)) |-> $past(tick16));
endmodule

bind uart_cts_tx utx_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .cts_en   (cts_en),
    .cts_n    (cts_n),
    .in_ready (in_ready),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/tb_uart_cts_tx.sv
module tb_uart_cts_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       one_x_mode = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] stop_code = 2'd1;
    logic       cts_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;
    logic       busy;

    int checks = 0;
    int errors = 0;

    localparam int MAXS = 16384;
    logic samp [MAXS];
    int   nsamp = 0;
    int   rd = 0;
    logic [1:0] tdiv = 2'd0;

    always #5 clk = ~clk;

    uart_cts_tx dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .one_x_mode(one_x_mode),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
        .stop_code(stop_code), .cts_en(cts_en), .cts_n(cts_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .txd(txd), .busy(busy)
    );

    // tick every fourth cycle, driven like a register
    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    // record the line value seen by every tick
    always @(negedge clk) begin
        if (rst_n && tick16 && nsamp < MAXS) begin
            samp[nsamp] = txd;
            nsamp = nsamp + 1;
        end
    end

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] lc;
        logic       par;
        logic       odd;
        logic [1:0] sc;
        logic       x1;
        logic [5:0] stopt;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hA5, 2'd3, 1'b0, 1'b0, 2'd1, 1'b0, 6'd16},
        '{8'h3C, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 6'd9},
        '{8'h5B, 2'd2, 1'b1, 1'b1, 2'd2, 1'b0, 6'd24},
        '{8'h16, 2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 6'd32},
        '{8'h1D, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 6'd16},
        '{8'hC3, 2'd0, 1'b1, 1'b1, 2'd2, 1'b0, 6'd24},
        '{8'h96, 2'd3, 1'b1, 1'b0, 2'd1, 1'b1, 6'd1},
        '{8'h4E, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 6'd2}
    };

    task automatic chk(input logic ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d);
        in_data  = d;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic check_frame(input logic [7:0] d, input int len, input logic par,
                               input logic odd, input int stopt, input logic x1,
                               input logic exact, input string tag);
        int   bt;
        int   p;
        int   nb;
        int   bad;
        int   run;
        int   q;
        logic pb;
        logic eb [10];
        bt  = x1 ? 1 : 16;
        p   = rd;
        bad = 0;
        while (p < nsamp && samp[p] === 1'b1) p++;
        nb = 1 + len + (par ? 1 : 0);
        pb = odd;
        eb[0] = 1'b0;
        for (int i = 0; i < len; i++) begin
            eb[i+1] = d[i];
            pb = pb ^ d[i];
        end
        if (par) eb[len+1] = pb;
        for (int k = 0; k < nb; k++) begin
            for (int j = 0; j < bt; j++) begin
                if (p + k*bt + j >= nsamp) bad++;
                else if (samp[p + k*bt + j] !== eb[k]) bad++;
            end
        end
        chk(bad == 0, {tag, " frame bit samples mismatching"}, bad, 0);
        q = p + nb*bt;
        run = 0;
        while (q < nsamp && samp[q] === 1'b1) begin
            run++;
            q++;
        end
        if (exact) chk(run == stopt, {tag, " stop ticks"}, run, stopt);
        else       chk(run >= stopt, {tag, " stop ticks at least"}, run, stopt);
        rd = q;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int zeros;
        string tg;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd after reset", txd, 1);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);

        // table: each vector sent twice back to back
        for (int v = 0; v < 8; v++) begin
            one_x_mode = VECS[v].x1;
            len_code   = VECS[v].lc;
            par_en     = VECS[v].par;
            par_odd    = VECS[v].odd;
            stop_code  = VECS[v].sc;
            rd = nsamp;
            if (VECS[v].x1) tg = "R7 one-x";
            else if (VECS[v].lc == 2'd0 && VECS[v].sc == 2'd0) tg = "R6 five-bit";
            else tg = "R2 R3 R4 R5 R11 frame";
            send(VECS[v].d);
            send(~VECS[v].d);
            wait_idle();
            check_frame(VECS[v].d, 5 + int'(VECS[v].lc), VECS[v].par, VECS[v].odd,
                        int'(VECS[v].stopt), VECS[v].x1, 1'b1, tg);
            check_frame(~VECS[v].d, 5 + int'(VECS[v].lc), VECS[v].par, VECS[v].odd,
                        int'(VECS[v].stopt), VECS[v].x1, 1'b0, tg);
        end

        // R7: stop_code[0] ignored in one-x mode (11 gives 2 ticks)
        one_x_mode = 1'b1; len_code = 2'd3; par_en = 1'b0; stop_code = 2'd3;
        rd = nsamp;
        send(8'h81);
        send(8'h7E);
        wait_idle();
        check_frame(8'h81, 8, 1'b0, 1'b0, 2, 1'b1, 1'b1, "R7 stop low bit ignored");
        check_frame(8'h7E, 8, 1'b0, 1'b0, 2, 1'b1, 1'b0, "R7 stop low bit ignored");

        // R11: in_ready closed during the start bit
        one_x_mode = 1'b0; stop_code = 2'd1;
        rd = nsamp;
        send(8'hF0);
        while (txd !== 1'b0) @(negedge clk);
        chk(in_ready === 1'b0, "R11 in_ready during start bit", in_ready, 0);
        wait_idle();
        check_frame(8'hF0, 8, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R11 frame");

        // R8: gated start, then R9: mid-frame change ignored
        cts_en = 1'b1; cts_n = 1'b1;
        rd = nsamp;
        send(8'h5A);
        repeat (200) @(negedge clk);
        zeros = 0;
        for (int i = rd; i < nsamp; i++) if (samp[i] !== 1'b1) zeros++;
        chk(zeros == 0, "R8 no start bit while cts negated", zeros, 0);
        chk(busy === 1'b0, "R8 busy while cts negated", busy, 0);
        chk(in_ready === 1'b0, "R11 in_ready with character queued", in_ready, 0);
        rd = nsamp;
        cts_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1, "R8 start after cts asserted", busy, 1);
        repeat (100) @(negedge clk);
        cts_n = 1'b1;
        wait_idle();
        check_frame(8'h5A, 8, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R9 cts change mid-frame");

        // R10: gating disabled, cts_n high does not block
        cts_en = 1'b0;
        rd = nsamp;
        send(8'h33);
        wait_idle();
        check_frame(8'h33, 8, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R10 cts ignored when disabled");
        cts_n = 1'b0;

        // R12: format captured at acceptance
        len_code = 2'd3; par_en = 1'b0; stop_code = 2'd1;
        rd = nsamp;
        send(8'hC9);
        len_code = 2'd0; par_en = 1'b1; par_odd = 1'b1; stop_code = 2'd3;
        wait_idle();
        check_frame(8'hC9, 8, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R12 format held");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule